// File: doc/BRIEF.md
# Fractional-Frequency PWM Generator with Boundary-Aligned Reconfiguration

This block drives up to four pulse-width-modulated outputs. Each channel sets its frequency with a phase accumulator rather than a terminal count. An unsigned increment is added to an accumulator on every clock, and one output period ends each time the accumulator carries out of its top bit. The period is therefore 2^W / increment clocks, where W is the accumulator width, and fractional frequencies are available. Duty is held as an 8-bit inverted divider. The output is high while the top eight accumulator bits exceed the divider.

Software programs each channel through a single 32-bit word in a small memory-mapped register space. New increment and divider values land in a staging copy. They reach the generator only after software raises a request bit, and only at the start of the next output period. At that same edge the hardware drops the request bit, so software can poll it to see that the change has been taken. While a request is pending, new field values are refused. A channel that is switched off holds its accumulator at zero and drives its output low. When it is switched back on, it starts a fresh period.

Top module: `frac_pwm`

## Requirements
- R1: Channel k's register is selected at byte address k*0x400 with address bits 9:0 all zero. Writes to any other offset, or to a channel index at or above NUM_CH, change nothing, and reads there return 0.
- R2: Register layout: bit 31 is enable, bit 30 is update request, bits 8 to 8+BU_W-1 hold the base increment, and bits 7:0 hold the on-time divider. A read returns the staged increment and divider, the enable bit and the live request bit. All other bits read 0.
- R3: While enabled, the output is high when the top 8 accumulator bits are greater than the active divider. A divider of 0 gives a constant high output, and a divider of 255 gives a constant low output.
- R4: While enabled, the accumulator adds the active increment on every clock, so the output period is 2^BU_W / increment clocks (8 clocks for increment 8192 and 16 clocks for 4096 when BU_W=16).
- R5: With the channel enabled and a request pending, the staged values become active at the clock edge where the accumulator carries out, and the request bit clears at that same edge. Before that edge the output follows the old values.
- R6: While the channel is disabled, a pending request is taken at the next clock edge.
- R7: While the request bit is set, writes leave the staged increment and divider unchanged.
- R8: With an active increment of 0 and the channel enabled, no output period starts, and a pending request stays pending.
- R9: With enable at 0, the output is low and the accumulator is held at 0. After enabling, the output follows the active values from an accumulator value of 0.
- R10: After reset, every register reads 0 and every output is low.
- R11: Channels run independently; a write to one channel does not alter another channel's register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the accumulators and registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational from registered state |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The bench builds the block with four channels and a 16-bit increment. Both window decode bits are therefore exercised, and periods stay short enough (8 or 16 clocks for power-of-two increments) to count every high sample over whole periods. It measures duty across a table of increment and divider pairs, and measures the spacing of rising edges. It also times the request bit's drop against the output change on a channel whose old and new dividers force opposite constant levels. The 22-bit increment variant is not built; it changes only field width and period length.

// File: rtl/frac_pwm_pkg.sv
package frac_pwm_pkg;
    localparam int REG_W         = 32;
    localparam int EN_BIT        = 31;
    localparam int UPD_BIT       = 30;
    localparam int BU_LSB        = 8;
    localparam int DIV_W         = 8;
    localparam int WIN_LG        = 10;
    localparam logic [DIV_W-1:0] DIV_ZERO = '0;
endpackage

// File: rtl/frac_pwm_regdec.sv
module frac_pwm_regdec
    import frac_pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output logic [NUM_CH-1:0] rd_sel,
    output logic [NUM_CH-1:0] wr_sel
);
    localparam int SEL_W = ADDR_W - WIN_LG;

    logic              offset_ok;
    logic [SEL_W-1:0]  ch_idx;

    always_comb begin
        offset_ok = (addr[WIN_LG-1:0] == '0);
        ch_idx    = addr[ADDR_W-1:WIN_LG];
        for (int k = 0; k < NUM_CH; k++) begin
            rd_sel[k] = offset_ok && (ch_idx == SEL_W'(k));
            wr_sel[k] = rd_sel[k] && wr_en;
        end
    end
endmodule

// File: rtl/frac_pwm_chan.sv
module frac_pwm_chan
    import frac_pwm_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    output logic               pwm,
    output logic               en_o,
    output logic               upd_o,
    output logic               wrap_o,
    output logic [BU_W+DIV_W-1:0] stage_o
);
    typedef struct packed {
        logic             en;
        logic             upd;
        logic [BU_W-1:0]  bu_stg;
        logic [DIV_W-1:0] div_stg;
        logic [BU_W-1:0]  bu_act;
        logic [DIV_W-1:0] div_act;
        logic [BU_W-1:0]  acc;
    } chan_state_t;

    chan_state_t st_q, st_d;

    logic [BU_W:0]      sum_w;
    logic               wrap_w;
    logic               take_w;
    logic [DIV_W-1:0]   phase_top;

    always_comb begin
        st_d   = st_q;
        sum_w  = {1'b0, st_q.acc} + {1'b0, st_q.bu_act};
        wrap_w = st_q.en && sum_w[BU_W];
        take_w = st_q.upd && (wrap_w || !st_q.en);

        if (take_w) begin
            st_d.bu_act  = st_q.bu_stg;
            st_d.div_act = st_q.div_stg;
            st_d.upd     = 1'b0;
        end

        if (wr_stb) begin
            st_d.en = wdata[EN_BIT];
            if (!st_q.upd) begin
                st_d.bu_stg  = wdata[BU_LSB +: BU_W];
                st_d.div_stg = wdata[DIV_W-1:0];
            end
            if (wdata[UPD_BIT] && !take_w) begin
                st_d.upd = 1'b1;
            end
        end

        if (st_q.en && st_d.en) begin
            st_d.acc = sum_w[BU_W-1:0];
        end else begin
            st_d.acc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        phase_top = st_q.acc[BU_W-1 -: DIV_W];
        pwm = st_q.en && ((st_q.div_act == DIV_ZERO) || (phase_top > st_q.div_act));
        rdata = '0;
        rdata[EN_BIT]            = st_q.en;
        rdata[UPD_BIT]           = st_q.upd;
        rdata[BU_LSB +: BU_W]    = st_q.bu_stg;
        rdata[DIV_W-1:0]         = st_q.div_stg;
        en_o    = st_q.en;
        upd_o   = st_q.upd;
        wrap_o  = wrap_w;
        stage_o = {st_q.bu_stg, st_q.div_stg};
    end
endmodule

// File: rtl/frac_pwm.sv
module frac_pwm
    import frac_pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int BU_W   = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int STAGE_W = BU_W + DIV_W;

    logic [NUM_CH-1:0]              rd_sel;
    logic [NUM_CH-1:0]              wr_sel;
    logic [NUM_CH-1:0][REG_W-1:0]   ch_rdata;
    logic [NUM_CH-1:0]              en_vec;
    logic [NUM_CH-1:0]              upd_vec;
    logic [NUM_CH-1:0]              wrap_vec;
    logic [NUM_CH-1:0][STAGE_W-1:0] stage_vec;

    frac_pwm_regdec #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr   (reg_addr),
        .wr_en  (reg_wr_en),
        .rd_sel (rd_sel),
        .wr_sel (wr_sel)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        frac_pwm_chan #(
            .BU_W (BU_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (wr_sel[k]),
            .wdata   (reg_wdata),
            .rdata   (ch_rdata[k]),
            .pwm     (pwm_out[k]),
            .en_o    (en_vec[k]),
            .upd_o   (upd_vec[k]),
            .wrap_o  (wrap_vec[k]),
            .stage_o (stage_vec[k])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (rd_sel[k]) begin
                reg_rdata = reg_rdata | ch_rdata[k];
            end
        end
    end
endmodule

// File: rtl/frac_pwm_chk.sv
module frac_pwm_chk #(
    parameter int NUM_CH = 4,
    parameter int BU_W   = 16
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_CH-1:0]               pwm_out,
    input logic [NUM_CH-1:0]               en_vec,
    input logic [NUM_CH-1:0]               upd_vec,
    input logic [NUM_CH-1:0]               wrap_vec,
    input logic [NUM_CH-1:0][BU_W+7:0]     stage_vec
);
    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        assert_low_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !en_vec[k] |-> !pwm_out[k]);

        assert_take_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(upd_vec[k]) |-> $past(wrap_vec[k] || !en_vec[k]));

        assert_pending_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_vec[k] && en_vec[k] && !wrap_vec[k]) |=> upd_vec[k]);

        assert_stage_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
            upd_vec[k] |=> $stable(stage_vec[k]));
    end
endmodule

bind frac_pwm frac_pwm_chk #(
    .NUM_CH (NUM_CH),
    .BU_W   (BU_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_out   (pwm_out),
    .en_vec    (en_vec),
    .upd_vec   (upd_vec),
    .wrap_vec  (wrap_vec),
    .stage_vec (stage_vec)
);

// File: tb/frac_pwm_tb.sv
module frac_pwm_tb;
    localparam int NUM_CH = 4;
    localparam int BU_W   = 16;
    localparam int ADDR_W = 12;
    localparam logic [31:0] EN  = 32'h8000_0000;
    localparam logic [31:0] UPD = 32'h4000_0000;

    typedef struct packed {
        logic [15:0] bu;
        logic [7:0]  div;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'd4096,  8'd0},
        '{16'd4096,  8'd255},
        '{16'd4096,  8'd128},
        '{16'd4096,  8'd64},
        '{16'd8192,  8'd100},
        '{16'd16384, 8'd200},
        '{16'd16384, 8'd150}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NUM_CH-1:0] pwm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    frac_pwm #(.NUM_CH(NUM_CH), .BU_W(BU_W), .ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [31:0] cfg(input logic [15:0] bu, input logic [7:0] dv);
        return {8'h00, bu, dv};
    endfunction

    function automatic int exp_high(input logic [15:0] bu, input logic [7:0] dv);
        int n = 0;
        for (int i = 0; i < 16; i++) begin
            logic [15:0] ph;
            ph = 16'(i * int'(bu));
            if (dv == 8'd0 || ph[15:8] > dv) n++;
        end
        return n;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wra(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic wr(input int ch, input logic [31:0] d);
        wra(ADDR_W'(ch * 1024), d);
    endtask

    task automatic rda(input logic [ADDR_W-1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rd(input int ch, output logic [31:0] v);
        rda(ADDR_W'(ch * 1024), v);
    endtask

    task automatic load(input int ch, input logic [15:0] bu, input logic [7:0] dv);
        wr(ch, 32'h0);
        wr(ch, UPD | cfg(bu, dv));
        wr(ch, EN | cfg(bu, dv));
    endtask

    task automatic period_of(input int ch, output int p);
        logic prev;
        int   guard;
        p = 0;
        guard = 0;
        prev = pwm_out[ch];
        @(negedge clk);
        while (!( !prev && pwm_out[ch]) && guard < 100) begin
            prev = pwm_out[ch];
            @(negedge clk);
            guard++;
        end
        prev = pwm_out[ch];
        guard = 0;
        do begin
            @(negedge clk);
            p++;
            guard++;
            if (!prev && pwm_out[ch]) break;
            prev = pwm_out[ch];
        end while (guard < 100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int          n;
        int          p;
        bit          stayed;

        // R10: reset state
        repeat (5) @(negedge clk);
        check("R10 outputs low in reset", 32'(pwm_out), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < NUM_CH; c++) begin
            rd(c, v);
            check("R10 register zero after reset", v, 32'h0);
        end
        check("R10 outputs low after reset", 32'(pwm_out), 32'h0);

        // R1 / R2: decode and field layout
        wr(2, 32'h0BCD_EF5A);
        rd(2, v);
        check("R2 readback masks reserved bits", v, 32'h00CD_EF5A);
        rd(1, v);
        check("R1 neighbour channel untouched", v, 32'h0);
        wra(12'h804, 32'h0000_1234);
        rd(2, v);
        check("R1 nonzero offset write ignored", v, 32'h00CD_EF5A);
        rda(12'h804, v);
        check("R1 nonzero offset reads zero", v, 32'h0);

        // R3: duty table
        foreach (VECS[i]) begin
            load(0, VECS[i].bu, VECS[i].div);
            repeat (4) @(negedge clk);
            n = 0;
            for (int s = 0; s < 16; s++) begin
                if (pwm_out[0]) n++;
                @(negedge clk);
            end
            check("R3 high samples per 16 clocks", 32'(n), 32'(exp_high(VECS[i].bu, VECS[i].div)));
        end

        // R4: period from increment
        load(0, 16'd8192, 8'd128);
        period_of(0, p);
        check("R4 period for increment 8192", 32'(p), 32'd8);
        load(0, 16'd4096, 8'd128);
        period_of(0, p);
        check("R4 period for increment 4096", 32'(p), 32'd16);

        // R9: restart from zero, then disable forces low
        load(0, 16'd4096, 8'd128);
        n = 0;
        while (!pwm_out[0] && n < 40) begin
            n++;
            @(negedge clk);
        end
        check("R9 low samples after enable", 32'(n), 32'd9);
        wr(0, cfg(16'd4096, 8'd128));
        n = 0;
        for (int s = 0; s < 20; s++) begin
            if (pwm_out[0]) n++;
            @(negedge clk);
        end
        check("R9 output low while disabled", 32'(n), 32'd0);

        // R5: deferred take at the boundary
        load(1, 16'd4096, 8'd0);
        repeat (3) @(negedge clk);
        wr(1, EN | UPD | cfg(16'd4096, 8'd255));
        rd(1, v);
        check("R2 live request bit reads set", 32'(v[30]), 32'd1);
        check("R5 old duty still in force", 32'(pwm_out[1]), 32'd1);
        n = 0;
        stayed = 1'b1;
        rd(1, v);
        while (v[30] && n < 40) begin
            if (!pwm_out[1]) stayed = 1'b0;
            @(negedge clk);
            n++;
            rd(1, v);
        end
        check("R5 request clears within one period", 32'(n >= 1 && n <= 16), 32'd1);
        check("R5 output held until boundary", 32'(stayed), 32'd1);
        check("R5 new duty at clear edge", 32'(pwm_out[1]), 32'd0);

        // R7: field writes refused while pending
        wr(1, EN | UPD | cfg(16'd4096, 8'd0));
        wr(1, EN | cfg(16'd8192, 8'd77));
        rd(1, v);
        check("R7 staged fields kept", v & 32'h00FF_FFFF, cfg(16'd4096, 8'd0));
        repeat (20) @(negedge clk);
        rd(1, v);
        check("R5 request cleared after boundary", v, EN | cfg(16'd4096, 8'd0));
        n = 0;
        for (int s = 0; s < 16; s++) begin
            if (pwm_out[1]) n++;
            @(negedge clk);
        end
        check("R5 staged duty applied", 32'(n), 32'd16);

        // R11: independence
        check("R11 only channel 1 driving", 32'(pwm_out), 32'h2);

        // R8 / R6: zero increment never reaches a boundary
        wr(3, UPD | cfg(16'd0, 8'd0));
        wr(3, EN);
        wr(3, EN | UPD | cfg(16'd4096, 8'd9));
        repeat (40) @(negedge clk);
        rd(3, v);
        check("R8 request stays pending", 32'(v[30]), 32'd1);
        wr(3, 32'h0);
        @(negedge clk);
        rd(3, v);
        check("R6 taken while disabled", v, cfg(16'd4096, 8'd9));
        rd(1, v);
        check("R11 channel 1 register intact", v, EN | cfg(16'd4096, 8'd0));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule